// File: doc/BRIEF.md
# Iterative Integer Divider with Deferred-Exception Control

This block divides two 32-bit operands, signed or unsigned, and hands back a quotient tagged with the index of the general register it is meant for. A single start pulse loads the operands, the signedness select, a 6-bit destination index, a non-excepting flag and an overflow-saturation control. A restoring datapath then produces one quotient bit per cycle. After a fixed latency the block raises a one-cycle valid strobe. With that strobe it presents the quotient, a register-write enable, a 2-bit exception code, the echoed destination index, and a 64-bit one-hot strobe. That strobe clears the deferred-exception flag of the destination register.

Two operand patterns are special. The first is a zero divisor: no quotient is written and a divide-by-zero code is reported. The second is the signed most-negative value divided by minus one: an overflow code is reported and a result is still written. The saturation control picks that result. An instruction pipeline starts an operation when `busy_o` is low and retires it on `valid_o`. Trap handling stays outside the block.

Top module: `int_div_unit`

## Requirements
- R1: An accepted start (start_i high while busy_o is low, sampled on a rising edge) yields valid_o high for exactly one cycle, DW+1 rising edges later. busy_o is high from the accepting edge until that result edge.
- R2: With signed_i low, quot_o is the unsigned floor of op_a_i / op_b_i, wr_en_o is 1 and exc_o is 0 (no exception) for any nonzero divisor.
- R3: With signed_i high and no special case, quot_o is the two's-complement quotient truncated toward zero, wr_en_o is 1 and exc_o is 0.
- R4: A signed divide of 0x80000000 by 0xFFFFFFFF reports exc_o = 1 (overflow) with wr_en_o = 1. quot_o is 0x7FFFFFFF when ede_i was high at start and 0x80000000 when it was low.
- R5: A zero divisor in either mode reports exc_o = 2 (divide by zero), with wr_en_o = 0 and quot_o = 0.
- R6: An unsigned divide never reports overflow: 0x80000000 / 0xFFFFFFFF unsigned gives quotient 0 and exc_o = 0.
- R7: When nonexc_i was high at start and the result has exc_o = 0, ne_clr_o carries a single 1 at bit position tgt for the valid cycle. In every other case and cycle, ne_clr_o is all zero.
- R8: A start pulse while busy_o is high is ignored: it produces no extra result and does not alter the result in flight.
- R9: After reset, valid_o, busy_o, wr_en_o and ne_clr_o are all 0.
- R10: tgt_o during the valid cycle equals the tgt_i captured at the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, honoured only while idle |
| op_a_i | input | 32 | Dividend |
| op_b_i | input | 32 | Divisor |
| signed_i | input | 1 | 1 = signed divide, 0 = unsigned |
| tgt_i | input | 6 | Destination register index |
| nonexc_i | input | 1 | Non-excepting operation |
| ede_i | input | 1 | Overflow result select (1 saturates to 0x7FFFFFFF) |
| busy_o | output | 1 | Operation in flight |
| valid_o | output | 1 | One-cycle result strobe |
| quot_o | output | 32 | Quotient |
| wr_en_o | output | 1 | Register write enable, qualified by valid_o |
| exc_o | output | 2 | 0 none, 1 overflow, 2 divide by zero |
| ne_clr_o | output | 64 | One-hot clear strobe for the deferred-exception flag |
| tgt_o | output | 6 | Destination index of the result |

## Verification
Every result of the block, whether quotient, write enable, exception code, index or clear strobe, is due in a single cycle. That cycle comes DW+1 rising edges after the accepting edge, with no early exit for the special cases. The driver records the cycle number of the accepting edge and pushes the expected item with a due cycle of that number plus DW+1. The monitor samples on falling edges and checks that each valid strobe arrives exactly on the due cycle of the oldest queued item. A strobe with an empty queue, or a queue left with items at the end, counts as a failure, which catches a start taken while busy.

// File: rtl/int_div_pkg.sv
package int_div_pkg;
  typedef enum logic [1:0] {
    EXC_NONE = 2'd0,
    EXC_OVF  = 2'd1,
    EXC_DVZ  = 2'd2
  } exc_e;
endpackage

// File: rtl/div_prep.sv
module div_prep
  import int_div_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          sgn_i,
  output logic [DW-1:0] mag_a_o,
  output logic [DW-1:0] mag_b_o,
  output logic          neg_q_o,
  output exc_e          exc_o
);
  localparam logic [DW-1:0] MOST_NEG = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] ALL_ONES = {DW{1'b1}};

  logic neg_a, neg_b, dvz, ovf;

  always_comb begin
    neg_a   = sgn_i & a_i[DW-1];
    neg_b   = sgn_i & b_i[DW-1];
    mag_a_o = neg_a ? (~a_i + 1'b1) : a_i;
    mag_b_o = neg_b ? (~b_i + 1'b1) : b_i;
    neg_q_o = neg_a ^ neg_b;
    dvz     = (b_i == '0);
    ovf     = sgn_i & (a_i == MOST_NEG) & (b_i == ALL_ONES);
    if (dvz)      exc_o = EXC_DVZ;
    else if (ovf) exc_o = EXC_OVF;
    else          exc_o = EXC_NONE;
  end
endmodule

// File: rtl/div_core.sv
module div_core #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] dividend_i,
  input  logic [DW-1:0] divisor_i,
  output logic          done_o,
  output logic [DW-1:0] quot_o
);
  localparam int unsigned CW = $clog2(DW + 1);

  logic [DW-1:0] rem_q, quo_q, dvs_q;
  logic [CW-1:0] cnt_q;
  logic [DW:0]   shifted, diff;
  logic          ge;

  always_comb begin
    shifted = {rem_q, quo_q[DW-1]};
    diff    = shifted - {1'b0, dvs_q};
    ge      = ~diff[DW];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else if (load_i) begin
      rem_q  <= '0;
      quo_q  <= dividend_i;
      dvs_q  <= divisor_i;
      cnt_q  <= CW'(DW);
      done_o <= 1'b0;
    end else if (cnt_q != '0) begin
      rem_q  <= ge ? diff[DW-1:0] : shifted[DW-1:0];
      quo_q  <= {quo_q[DW-2:0], ge};
      cnt_q  <= cnt_q - 1'b1;
      done_o <= (cnt_q == CW'(1));
    end else begin
      done_o <= 1'b0;
    end
  end

  assign quot_o = quo_q;
endmodule

// File: rtl/div_out.sv
module div_out
  import int_div_pkg::*;
#(
  parameter int unsigned DW   = 32,
  parameter int unsigned NREG = 64,
  parameter int unsigned IW   = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            done_i,
  input  logic [DW-1:0]   raw_q_i,
  input  logic            neg_q_i,
  input  exc_e            exc_i,
  input  logic            ede_i,
  input  logic            nonexc_i,
  input  logic [IW-1:0]   tgt_i,
  output logic            valid_o,
  output logic [DW-1:0]   quot_o,
  output logic            wr_en_o,
  output logic [1:0]      exc_o,
  output logic [NREG-1:0] ne_clr_o,
  output logic [IW-1:0]   tgt_o
);
  localparam logic [DW-1:0] SAT_POS = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] MOST_NEG = {1'b1, {(DW-1){1'b0}}};

  logic [DW-1:0]   fixed_q, sel_q;
  logic            clr_sel;
  logic [NREG-1:0] clr_vec;

  always_comb begin
    fixed_q = neg_q_i ? (~raw_q_i + 1'b1) : raw_q_i;
    unique case (exc_i)
      EXC_OVF: sel_q = ede_i ? SAT_POS : MOST_NEG;
      EXC_DVZ: sel_q = '0;
      default: sel_q = fixed_q;
    endcase
    clr_sel = nonexc_i & (exc_i == EXC_NONE);
  end

  for (genvar g = 0; g < NREG; g++) begin : g_clr
    assign clr_vec[g] = clr_sel & (tgt_i == IW'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      quot_o   <= '0;
      wr_en_o  <= 1'b0;
      exc_o    <= EXC_NONE;
      ne_clr_o <= '0;
      tgt_o    <= '0;
    end else if (done_i) begin
      valid_o  <= 1'b1;
      quot_o   <= sel_q;
      wr_en_o  <= (exc_i != EXC_DVZ);
      exc_o    <= exc_i;
      ne_clr_o <= clr_vec;
      tgt_o    <= tgt_i;
    end else begin
      valid_o  <= 1'b0;
      wr_en_o  <= 1'b0;
      ne_clr_o <= '0;
    end
  end
endmodule

// File: rtl/int_div_unit.sv
module int_div_unit
  import int_div_pkg::*;
#(
  parameter int unsigned DW   = 32,
  parameter int unsigned NREG = 64,
  parameter int unsigned IW   = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [DW-1:0]   op_a_i,
  input  logic [DW-1:0]   op_b_i,
  input  logic            signed_i,
  input  logic [IW-1:0]   tgt_i,
  input  logic            nonexc_i,
  input  logic            ede_i,
  output logic            busy_o,
  output logic            valid_o,
  output logic [DW-1:0]   quot_o,
  output logic            wr_en_o,
  output logic [1:0]      exc_o,
  output logic [NREG-1:0] ne_clr_o,
  output logic [IW-1:0]   tgt_o
);
  logic          accept, busy_q, core_done;
  logic [DW-1:0] mag_a, mag_b, raw_q;
  logic          neg_q_d, neg_q_q;
  exc_e          exc_d, exc_q;
  logic          ede_q, nonexc_q;
  logic [IW-1:0] tgt_q;

  assign accept = start_i & ~busy_q;

  div_prep #(.DW(DW)) u_prep (
    .a_i    (op_a_i),
    .b_i    (op_b_i),
    .sgn_i  (signed_i),
    .mag_a_o(mag_a),
    .mag_b_o(mag_b),
    .neg_q_o(neg_q_d),
    .exc_o  (exc_d)
  );

  div_core #(.DW(DW)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept),
    .dividend_i(mag_a),
    .divisor_i (mag_b),
    .done_o    (core_done),
    .quot_o    (raw_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      neg_q_q  <= 1'b0;
      exc_q    <= EXC_NONE;
      ede_q    <= 1'b0;
      nonexc_q <= 1'b0;
      tgt_q    <= '0;
    end else if (accept) begin
      busy_q   <= 1'b1;
      neg_q_q  <= neg_q_d;
      exc_q    <= exc_d;
      ede_q    <= ede_i;
      nonexc_q <= nonexc_i;
      tgt_q    <= tgt_i;
    end else if (core_done) begin
      busy_q   <= 1'b0;
    end
  end

  div_out #(.DW(DW), .NREG(NREG), .IW(IW)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .done_i  (core_done),
    .raw_q_i (raw_q),
    .neg_q_i (neg_q_q),
    .exc_i   (exc_q),
    .ede_i   (ede_q),
    .nonexc_i(nonexc_q),
    .tgt_i   (tgt_q),
    .valid_o (valid_o),
    .quot_o  (quot_o),
    .wr_en_o (wr_en_o),
    .exc_o   (exc_o),
    .ne_clr_o(ne_clr_o),
    .tgt_o   (tgt_o)
  );

  assign busy_o = busy_q;
endmodule

// File: rtl/int_div_unit_chk.sv
module int_div_unit_chk #(
  parameter int unsigned DW   = 32,
  parameter int unsigned NREG = 64,
  parameter int unsigned IW   = $clog2(NREG)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic            busy_o,
  input logic            valid_o,
  input logic [DW-1:0]   quot_o,
  input logic            wr_en_o,
  input logic [1:0]      exc_o,
  input logic [NREG-1:0] ne_clr_o,
  input logic [IW-1:0]   tgt_o
);
  localparam int unsigned LW = $clog2(DW + 3);
  localparam logic [DW-1:0] SAT_POS = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] MOST_NEG = {1'b1, {(DW-1){1'b0}}};

  logic [LW-1:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                lat_q <= '0;
    else if (start_i && !busy_o) lat_q <= '0;
    else if (busy_o)            lat_q <= lat_q + 1'b1;
  end

  // R1
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  // R1
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (lat_q == LW'(DW + 1)));
  // R4
  ovf_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && exc_o == 2'd1) |-> (wr_en_o && (quot_o == SAT_POS || quot_o == MOST_NEG)));
  // R5
  dvz_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && exc_o == 2'd2) |-> (!wr_en_o && quot_o == '0));
  // R7
  ne_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ne_clr_o) |-> (valid_o && exc_o == 2'd0 && $countones(ne_clr_o) == 1 && ne_clr_o[tgt_o]));
  // R8
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || valid_o));
  // R8
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !busy_o);
  // R9
  wr_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !wr_en_o);
endmodule

bind int_div_unit int_div_unit_chk #(.DW(DW), .NREG(NREG), .IW(IW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_o  (busy_o),
  .valid_o (valid_o),
  .quot_o  (quot_o),
  .wr_en_o (wr_en_o),
  .exc_o   (exc_o),
  .ne_clr_o(ne_clr_o),
  .tgt_o   (tgt_o)
);

// File: tb/tb_int_div_unit.sv
module tb_int_div_unit;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int NREG = 64;
  localparam int IW = 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [DW-1:0]   op_a = '0, op_b = '0;
  logic            sgn = 1'b0, nonexc = 1'b0, ede = 1'b0;
  logic [IW-1:0]   tgt = '0;
  logic            busy_o, valid_o, wr_en_o;
  logic [DW-1:0]   quot_o;
  logic [1:0]      exc_o;
  logic [NREG-1:0] ne_clr_o;
  logic [IW-1:0]   tgt_o;

  int checks = 0, fails = 0;
  longint cyc = 0;
  int pushed = 0, seen = 0;
  bit done = 0;

  typedef struct packed {
    logic [DW-1:0]   q;
    logic            wr;
    logic [1:0]      exc;
    logic [IW-1:0]   tgt;
    logic [NREG-1:0] ne;
    longint          due;
  } item_t;

  item_t exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  int_div_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_a_i(op_a), .op_b_i(op_b),
    .signed_i(sgn), .tgt_i(tgt), .nonexc_i(nonexc), .ede_i(ede),
    .busy_o(busy_o), .valid_o(valid_o), .quot_o(quot_o), .wr_en_o(wr_en_o),
    .exc_o(exc_o), .ne_clr_o(ne_clr_o), .tgt_o(tgt_o)
  );

  task automatic check(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  // Monitor: pop and compare on every valid strobe
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      seen++;
      if (exp_q.size() == 0) begin
        check(0, $sformatf("R8 unexpected result: got q=%h expected none", quot_o));
      end else begin
        item_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(cyc == e.due, $sformatf("R1 %s latency: got cycle %0d expected %0d", t, cyc, e.due));
        check(quot_o == e.q && wr_en_o == e.wr && exc_o == e.exc,
          $sformatf("%s result: got q=%h wr=%0b exc=%0d expected q=%h wr=%0b exc=%0d",
                    t, quot_o, wr_en_o, exc_o, e.q, e.wr, e.exc));
        check(tgt_o == e.tgt, $sformatf("R10 %s tgt: got %0d expected %0d", t, tgt_o, e.tgt));
        check(ne_clr_o == e.ne, $sformatf("R7 %s ne_clr: got %h expected %h", t, ne_clr_o, e.ne));
      end
    end else if (rst_n && ne_clr_o != '0) begin
      check(0, $sformatf("R7 ne_clr outside valid: got %h expected 0", ne_clr_o));
    end
  end

  task automatic run_op(input logic [DW-1:0] a, input logic [DW-1:0] b, input logic s,
                        input int t, input logic nx, input logic ed, input string tag);
    item_t e;
    logic [DW-1:0] sq;
    e.tgt = IW'(t);
    e.ne  = '0;
    if (b == '0) begin
      e.q = '0; e.wr = 1'b0; e.exc = 2'd2;
    end else if (s && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin
      e.q = ed ? 32'h7FFF_FFFF : 32'h8000_0000; e.wr = 1'b1; e.exc = 2'd1;
    end else begin
      sq = $signed(a) / $signed(b);
      e.q = s ? sq : (a / b);
      e.wr = 1'b1; e.exc = 2'd0;
      if (nx) e.ne = NREG'(1) << t;
    end
    @(negedge clk);
    op_a = a; op_b = b; sgn = s; tgt = IW'(t); nonexc = nx; ede = ed; start = 1'b1;
    e.due = cyc + DW + 2;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    pushed++;
    @(negedge clk);
    start = 1'b0;
    while (busy_o) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "R1 watchdog: got hang expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(valid_o == 0 && busy_o == 0 && wr_en_o == 0 && ne_clr_o == '0,
      $sformatf("R9 reset state: got v=%0b b=%0b w=%0b ne=%h expected all 0",
                valid_o, busy_o, wr_en_o, ne_clr_o));
    rst_n = 1'b1;
    @(negedge clk);
    check(valid_o == 0 && busy_o == 0, $sformatf("R9 idle after reset: got v=%0b b=%0b expected 0 0",
                                               valid_o, busy_o));

    run_op(32'd100, 32'd7, 0, 3, 0, 0, "R2 100/7");
    run_op(32'hFFFF_FFFF, 32'd1, 0, 4, 0, 0, "R2 max/1");
    run_op(32'd5, 32'd10, 0, 5, 0, 0, "R2 5/10");
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 6, 0, 0, "R2 max/max");
    run_op(-32'sd7, 32'd2, 1, 7, 0, 0, "R3 -7/2");
    run_op(32'd7, -32'sd2, 1, 8, 0, 0, "R3 7/-2");
    run_op(-32'sd7, -32'sd2, 1, 9, 0, 0, "R3 -7/-2");
    run_op(32'h8000_0000, 32'd2, 1, 10, 0, 0, "R3 minneg/2");
    run_op(32'h8000_0000, 32'hFFFF_FFFF, 1, 11, 1, 1, "R4 overflow ede=1");
    run_op(32'h8000_0000, 32'hFFFF_FFFF, 1, 12, 0, 0, "R4 overflow ede=0");
    run_op(32'd42, 32'd0, 1, 13, 1, 0, "R5 signed div zero");
    run_op(32'd42, 32'd0, 0, 14, 0, 1, "R5 unsigned div zero");
    run_op(32'h8000_0000, 32'hFFFF_FFFF, 0, 15, 1, 1, "R6 unsigned no overflow");
    run_op(32'd81, 32'd9, 0, 0, 1, 0, "R7 nonexc tgt 0");
    run_op(-32'sd81, 32'd9, 1, 63, 1, 0, "R7 nonexc tgt 63");
    run_op(32'd1000, 32'd33, 0, 37, 1, 0, "R7 nonexc tgt 37");

    // R8: second start during busy must be dropped
    @(negedge clk);
    op_a = 32'd90; op_b = 32'd9; sgn = 0; tgt = 6'd20; nonexc = 0; ede = 0; start = 1'b1;
    begin
      item_t e;
      e.q = 32'd10; e.wr = 1; e.exc = 0; e.tgt = 6'd20; e.ne = '0; e.due = cyc + DW + 2;
      exp_q.push_back(e); tag_q.push_back("R8 first op"); pushed++;
    end
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    op_a = 32'd7; op_b = 32'd0; sgn = 1; tgt = 6'd21; nonexc = 1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (busy_o) @(negedge clk);
    repeat (DW + 6) @(negedge clk);

    for (int i = 0; i < 20; i++) begin
      logic [DW-1:0] a, b;
      a = $urandom;
      b = (i % 3 == 0) ? ($urandom & 32'hFF) + 1 : $urandom;
      run_op(a, b, i[0], (i * 5) % NREG, i[1], i[2], (i[0] ? "R3 random" : "R2 random"));
    end

    repeat (DW + 6) @(negedge clk);
    check(exp_q.size() == 0 && seen == pushed,
      $sformatf("R8 result count: got %0d seen, %0d queued expected %0d seen, 0 queued",
                seen, exp_q.size(), pushed));
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule